// File: doc/BRIEF.md
# Nibble-packed video RAM scanout with palette

This block holds a byte-wide video memory organised in columns and converts scan coordinates into pixel colours. Each memory byte carries two horizontally adjacent 4-bit pixels. Each 4-bit pixel selects one of sixteen palette entries. An entry packs a colour into one byte: blue in the top two bits, green in the middle three and red in the bottom three. Each field is widened to an 8-bit channel by weighted bit sums.

The scan side presents an x/y position with an enable. One cycle later it receives the colour and a valid flag. The CPU side shares the same memory and also decodes three things. The first is a window of sixteen palette registers. The second is a one-byte overlay select register. The third is the low address region where the video memory lives.

CPU writes to the low region always update video memory. CPU reads from the low region return video memory while the select register holds zero, and the external ROM byte otherwise. ROM contents, the processor and display sync generation sit outside the block.

Top module: `nib_vram_scan`

## Requirements
- R1: After reset, pix_valid is 0, the colour outputs are 0, cpu_rdata is 0 and the overlay select register is 0.
- R2: A scan of (x, y) reads the byte at column x>>1 (address bits 15:8) and row y (address bits 7:0). An even x shows bits 7:4 of that byte and an odd x shows bits 3:0.
- R3: pix_valid is 1 exactly one cycle after a scan with scan_en=1, x < 2*NUM_COLS and FIRST_ROW <= y <= LAST_ROW (6..245 by default). Otherwise it is 0, and the colour outputs are 0 whenever pix_valid is 0.
- R4: A palette byte p produces red = 33*p[0] + 71*p[1] + 151*p[2], green = 33*p[3] + 71*p[4] + 151*p[5] and blue = 71*p[6] + 151*p[7].
- R5: A CPU write to PAL_BASE+i (i = 0..15, chosen by address bits 3:0) sets palette entry i. It affects the very next pixel output, including a pixel scanned in the same cycle as the write.
- R6: A CPU write to SEL_ADDR stores the overlay select byte. A read in the video region returns the video memory byte when that byte is 0, and otherwise the rom_rdata value sampled with the read. The data appears on cpu_rdata one cycle after cpu_re.
- R7: A CPU write in the video region (address bits 15:8 < NUM_COLS) stores into video memory whatever the overlay select value is.
- R8: A CPU read outside the video region returns 0 on cpu_rdata.
- R9: When a scan and a CPU write hit the same byte in the same cycle, the pixel shows the byte's previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Scan request this cycle |
| scan_x | input | X_W | Horizontal pixel position |
| scan_y | input | 8 | Row |
| pix_valid | output | 1 | Colour outputs carry a visible pixel |
| pix_r | output | 8 | Red channel |
| pix_g | output | 8 | Green channel |
| pix_b | output | 8 | Blue channel |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | CPU write strobe |
| cpu_re | input | 1 | CPU read strobe |
| rom_rdata | input | 8 | Overlay ROM byte for the current CPU address |
| cpu_rdata | output | 8 | CPU read data, one cycle after cpu_re |

## Verification
The pixel colour and pix_valid are due one clock edge after the scan request, so the bench drives each request half a period before an edge and compares at the following falling edge. cpu_rdata follows the same one-edge rule. Palette writes show on the pixel sampled at that same falling edge, and memory writes only show on later scans. The bench model therefore applies a palette write before it predicts the pixel, and applies a memory or select write only after the comparison.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

   typedef struct packed {
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } rgb_t;

   // three-bit field to 8-bit channel with weights 33/71/151
   function automatic logic [7:0] widen3(input logic [2:0] f);
      logic [7:0] s;
      s = 8'd0;
      if (f[0]) s = s + 8'd33;
      if (f[1]) s = s + 8'd71;
      if (f[2]) s = s + 8'd151;
      return s;
   endfunction

   // two-bit field to 8-bit channel with weights 71/151
   function automatic logic [7:0] widen2(input logic [1:0] f);
      logic [7:0] s;
      s = 8'd0;
      if (f[0]) s = s + 8'd71;
      if (f[1]) s = s + 8'd151;
      return s;
   endfunction

endpackage

// File: rtl/nvs_vram.sv
module nvs_vram #(
   parameter int DEPTH = 2048,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic [AW-1:0] scan_addr,
   output logic [7:0]    scan_q,
   input  logic [AW-1:0] cpu_addr,
   input  logic          cpu_we,
   input  logic [7:0]    cpu_wdata,
   output logic [7:0]    cpu_q
);
   if (DEPTH < 2) $error("nvs_vram: DEPTH too small");

   logic [7:0] mem [DEPTH];

   // read-first on both ports
   always_ff @(posedge clk) begin
      scan_q <= mem[scan_addr];
      cpu_q  <= mem[cpu_addr];
      if (cpu_we) mem[cpu_addr] <= cpu_wdata;
   end
endmodule

// File: rtl/nvs_palette.sv
module nvs_palette
   import nvs_pkg::*;
#(
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [7:0]       wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output rgb_t             rgb
);
   localparam int N = 1 << IDX_W;

   if (IDX_W < 1 || IDX_W > 8) $error("nvs_palette: IDX_W out of range");

   logic [7:0] ent [N];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) ent[i] <= 8'd0;
      end else if (wr_en) begin
         ent[wr_idx] <= wr_data;
      end
   end

   logic [7:0] sel;
   assign sel   = ent[rd_idx];
   assign rgb.r = widen3(sel[2:0]);
   assign rgb.g = widen3(sel[5:3]);
   assign rgb.b = widen2(sel[7:6]);

   // R5
   pal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> ent[$past(wr_idx)] == $past(wr_data))
      else $error("palette entry not updated");
endmodule

// File: rtl/nib_vram_scan.sv
module nib_vram_scan
   import nvs_pkg::*;
#(
   parameter int          NUM_COLS  = 8,
   parameter int          X_W       = 9,
   parameter int          FIRST_ROW = 6,
   parameter int          LAST_ROW  = 245,
   parameter logic [15:0] PAL_BASE  = 16'hC000,
   parameter logic [15:0] SEL_ADDR  = 16'hC900,
   parameter bit          HI_FIRST  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           scan_en,
   input  logic [X_W-1:0] scan_x,
   input  logic [7:0]     scan_y,
   output logic           pix_valid,
   output logic [7:0]     pix_r,
   output logic [7:0]     pix_g,
   output logic [7:0]     pix_b,
   input  logic [15:0]    cpu_addr,
   input  logic [7:0]     cpu_wdata,
   input  logic           cpu_we,
   input  logic           cpu_re,
   input  logic [7:0]     rom_rdata,
   output logic [7:0]     cpu_rdata
);
   localparam int ROW_W = 8;
   localparam int CW    = $clog2(NUM_COLS);
   localparam int AW    = CW + ROW_W;
   localparam int DEPTH = NUM_COLS << ROW_W;
   localparam logic [X_W:0]     ACT_W = (X_W + 1)'(2 * NUM_COLS);
   localparam logic [8:0]       NCOL  = 9'(NUM_COLS);
   localparam logic [ROW_W-1:0] FR    = ROW_W'(FIRST_ROW);
   localparam logic [ROW_W-1:0] LR    = ROW_W'(LAST_ROW);

   if (NUM_COLS < 2 || NUM_COLS > 256) $error("NUM_COLS out of range");
   if (X_W - 1 < CW)                   $error("X_W too narrow for NUM_COLS");
   if (FIRST_ROW > LAST_ROW || LAST_ROW > 255) $error("bad visible row window");

   // ---------------- scan side ----------------
   logic [AW-1:0] scan_addr;
   logic          scan_vis;
   logic [7:0]    scan_byte;
   logic          vld_q, odd_q;
   logic [3:0]    nib;
   rgb_t          pal_rgb;

   assign scan_addr = {scan_x[CW:1], scan_y};
   assign scan_vis  = scan_en && ({1'b0, scan_x} < ACT_W) &&
                      (scan_y >= FR) && (scan_y <= LR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         odd_q <= 1'b0;
      end else begin
         vld_q <= scan_vis;
         odd_q <= scan_x[0];
      end
   end

   if (HI_FIRST) begin : g_hi_left
      assign nib = odd_q ? scan_byte[3:0] : scan_byte[7:4];
   end else begin : g_lo_left
      assign nib = odd_q ? scan_byte[7:4] : scan_byte[3:0];
   end

   assign pix_valid = vld_q;
   assign pix_r     = vld_q ? pal_rgb.r : 8'd0;
   assign pix_g     = vld_q ? pal_rgb.g : 8'd0;
   assign pix_b     = vld_q ? pal_rgb.b : 8'd0;

   // ---------------- CPU decode ----------------
   logic          in_vid, ram_we, pal_we;
   logic [AW-1:0] cpu_idx;
   logic [7:0]    ovl_q, rom_q, ram_cpu_q;
   logic          rd_ram_q, rd_rom_q;

   assign in_vid  = ({1'b0, cpu_addr[15:8]} < NCOL);
   assign cpu_idx = {cpu_addr[8+CW-1:8], cpu_addr[7:0]};
   assign ram_we  = cpu_we && in_vid;
   assign pal_we  = cpu_we && (cpu_addr[15:4] == PAL_BASE[15:4]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ovl_q    <= 8'd0;
         rom_q    <= 8'd0;
         rd_ram_q <= 1'b0;
         rd_rom_q <= 1'b0;
      end else begin
         if (cpu_we && cpu_addr == SEL_ADDR) ovl_q <= cpu_wdata;
         rom_q    <= rom_rdata;
         rd_ram_q <= cpu_re && in_vid && (ovl_q == 8'd0);
         rd_rom_q <= cpu_re && in_vid && (ovl_q != 8'd0);
      end
   end

   assign cpu_rdata = rd_ram_q ? ram_cpu_q : (rd_rom_q ? rom_q : 8'd0);

   nvs_vram #(.DEPTH(DEPTH), .AW(AW)) vram_i (
      .clk      (clk),
      .scan_addr(scan_addr),
      .scan_q   (scan_byte),
      .cpu_addr (cpu_idx),
      .cpu_we   (ram_we),
      .cpu_wdata(cpu_wdata),
      .cpu_q    (ram_cpu_q)
   );

   nvs_palette #(.IDX_W(4)) pal_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pal_we),
      .wr_idx (cpu_addr[3:0]),
      .wr_data(cpu_wdata),
      .rd_idx (nib),
      .rgb    (pal_rgb)
   );

   // R3
   row_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_en && scan_y < FR) |=> !pix_valid)
      else $error("pixel valid above visible window");

   // R3
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid |-> $past(scan_en))
      else $error("pixel valid without a scan request");

   // R6
   rom_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_re && in_vid && ovl_q != 8'd0) |=> cpu_rdata == $past(rom_rdata))
      else $error("overlay read did not return ROM byte");

   // R8
   outside_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_re && !in_vid) |=> cpu_rdata == 8'd0)
      else $error("read outside video region not zero");
endmodule

// File: tb/nib_vram_scan_tb_top.sv
`timescale 1ns/1ps
module nib_vram_scan_tb_top;
   localparam int NCOLS = 8;
   localparam int DEP   = NCOLS * 256;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scan_en = 1'b0;
   logic [8:0]  scan_x = '0;
   logic [7:0]  scan_y = '0;
   logic        pix_valid;
   logic [7:0]  pix_r, pix_g, pix_b;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        cpu_we = 1'b0;
   logic        cpu_re = 1'b0;
   logic [7:0]  rom_rdata = '0;
   logic [7:0]  cpu_rdata;

   always #5 clk = ~clk;

   nib_vram_scan dut_i (
      .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .scan_x(scan_x), .scan_y(scan_y),
      .pix_valid(pix_valid), .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_re(cpu_re),
      .rom_rdata(rom_rdata), .cpu_rdata(cpu_rdata)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   logic [7:0] m_mem [DEP];
   logic [7:0] m_pal [16];
   logic [7:0] m_ovl;

   function automatic logic [7:0] w3(input logic [2:0] f);
      return 8'((f[0] ? 33 : 0) + (f[1] ? 71 : 0) + (f[2] ? 151 : 0));
   endfunction
   function automatic logic [7:0] w2(input logic [1:0] f);
      return 8'((f[0] ? 71 : 0) + (f[1] ? 151 : 0));
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // one cycle: drive, clock, compare, update model
   task automatic step(input bit se, input logic [8:0] x, input logic [7:0] y,
                       input bit we, input logic [15:0] a, input logic [7:0] wd,
                       input bit re, input logic [7:0] rom, input string tag);
      logic [7:0] pal_n [16];
      logic       ev;
      logic [7:0] by, pe, er, eg, eb, erd;
      logic [3:0] nb;
      bit         vid;
      for (int i = 0; i < 16; i++) pal_n[i] = m_pal[i];
      if (we && a[15:4] == 12'hC00) pal_n[a[3:0]] = wd;   // R5 same-cycle effect
      vid = (a[15:8] < NCOLS);
      ev  = se && (x < 2 * NCOLS) && (y >= 6) && (y <= 245);
      by  = m_mem[(int'(x[3:1]) * 256) + int'(y)];          // R9 old contents
      nb  = x[0] ? by[3:0] : by[7:4];
      pe  = pal_n[nb];
      er  = ev ? w3(pe[2:0]) : 8'd0;
      eg  = ev ? w3(pe[5:3]) : 8'd0;
      eb  = ev ? w2(pe[7:6]) : 8'd0;
      erd = !vid ? 8'd0 : (m_ovl == 8'd0 ? m_mem[(int'(a[10:8]) * 256) + int'(a[7:0])] : rom);
      scan_en = se; scan_x = x; scan_y = y;
      cpu_we = we; cpu_addr = a; cpu_wdata = wd; cpu_re = re; rom_rdata = rom;
      @(posedge clk);
      @(negedge clk);
      scan_en = 1'b0; cpu_we = 1'b0; cpu_re = 1'b0;
      if (se) begin
         chk(pix_valid == ev, {tag, " R3 valid"}, 32'(pix_valid), 32'(ev));
         chk({pix_r, pix_g, pix_b} == {er, eg, eb}, {tag, " R2/R4 colour"},
             {8'h0, pix_r, pix_g, pix_b}, {8'h0, er, eg, eb});
      end
      if (re) chk(cpu_rdata == erd, {tag, " R6/R8 rdata"}, 32'(cpu_rdata), 32'(erd));
      if (we && vid) m_mem[(int'(a[10:8]) * 256) + int'(a[7:0])] = wd;  // R7
      if (we && a == 16'hC900) m_ovl = wd;
      for (int i = 0; i < 16; i++) m_pal[i] = pal_n[i];
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 16; i++) m_pal[i] = 8'd0;
      m_ovl = 8'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      chk(pix_valid == 1'b0, "R1 pix_valid", 32'(pix_valid), 0);
      chk({pix_r, pix_g, pix_b} == 24'd0, "R1 colour", 32'({pix_r, pix_g, pix_b}), 0);
      chk(cpu_rdata == 8'd0, "R1 cpu_rdata", 32'(cpu_rdata), 0);

      // fill memory through CPU writes (R7)
      for (int i = 0; i < DEP; i++)
         step(0, 0, 0, 1, 16'((i / 256) << 8 | (i % 256)), 8'($urandom), 0, 0, "fill");

      // R1: overlay select is zero after reset, reads return RAM
      step(0, 0, 0, 0, 0, 0, 0, 0, "idle");
      step(0, 0, 0, 0, 16'h0310, 0, 1, 8'hA5, "R1 overlay reset");

      // R4 palette expansion corners
      step(0, 0, 0, 1, 16'hC000, 8'hFF, 0, 0, "R4 pal");
      step(0, 0, 0, 1, 16'h0010, 8'h0F, 0, 0, "R7 ram");
      step(1, 9'd0, 8'd16, 0, 0, 0, 0, 0, "R4 all ones");
      step(1, 9'd1, 8'd16, 0, 0, 0, 0, 0, "R2 odd nibble");
      step(0, 0, 0, 1, 16'hC00F, 8'h49, 0, 0, "R4 pal");
      step(1, 9'd1, 8'd16, 0, 0, 0, 0, 0, "R4 mixed");
      // R3 row and column boundaries
      step(1, 9'd2, 8'd5, 0, 0, 0, 0, 0, "R3 row 5");
      step(1, 9'd2, 8'd6, 0, 0, 0, 0, 0, "R3 row 6");
      step(1, 9'd2, 8'd245, 0, 0, 0, 0, 0, "R3 row 245");
      step(1, 9'd2, 8'd246, 0, 0, 0, 0, 0, "R3 row 246");
      step(1, 9'd15, 8'd100, 0, 0, 0, 0, 0, "R3 last column");
      step(1, 9'd16, 8'd100, 0, 0, 0, 0, 0, "R3 past width");
      // R5 palette write in the same cycle as a scan
      step(1, 9'd0, 8'd16, 1, 16'hC000, 8'h12, 0, 0, "R5 same cycle");
      // R9 scan and write hitting the same byte
      step(1, 9'd4, 8'd50, 1, 16'h0232, 8'h77, 0, 0, "R9 collide");
      step(1, 9'd4, 8'd50, 0, 0, 0, 0, 0, "R9 after");
      // R6 overlay on, R7 write still reaches RAM
      step(0, 0, 0, 1, 16'hC900, 8'h01, 0, 0, "R6 sel");
      step(0, 0, 0, 0, 16'h0232, 0, 1, 8'h3C, "R6 rom read");
      step(0, 0, 0, 1, 16'h0232, 8'h5A, 0, 0, "R7 write under overlay");
      step(1, 9'd5, 8'd50, 0, 0, 0, 0, 0, "R7 scan after");
      step(0, 0, 0, 1, 16'hC900, 8'h00, 0, 0, "R6 sel off");
      step(0, 0, 0, 0, 16'h0232, 0, 1, 8'h3C, "R6 ram read");
      // R8 outside region
      step(0, 0, 0, 0, 16'hD000, 0, 1, 8'hEE, "R8 outside");

      // constrained random mix
      for (int k = 0; k < 3000; k++) begin
         int op;
         logic [15:0] a;
         op = int'($urandom % 5);
         a  = 16'($urandom);
         case (op)
            0: step(0, 0, 0, 1, {5'd0, a[10:0]}, 8'($urandom), 0, 0, "rand R7");
            1: step(1, 9'($urandom % 20), 8'($urandom), 1, {12'hC00, a[3:0]}, 8'($urandom), 0, 0, "rand R5");
            2: step(1, 9'($urandom % 20), 8'($urandom), 0, 0, 0, 0, 0, "rand R2");
            3: step(0, 0, 0, 0, a[15] ? a : {5'd0, a[10:0]}, 0, 1, 8'($urandom), "rand R6");
            default: step(0, 0, 0, 1, 16'hC900, ($urandom % 2) ? 8'd0 : 8'($urandom), 0, 0, "rand R6 sel");
         endcase
      end

      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule